// File: doc/BRIEF.md
# Serial Management Bus Register Slave

This block is a slave on a two-wire serial management bus that gives a bus host access to a small register file. SCL and SDA are oversampled by the system clock. Each line passes through a synchroniser and an edge detector, and the block works out START and STOP conditions from the sampled lines. The block answers to a 7-bit address. The upper five bits of that address are fixed, and the two lowest come from strap pins, so four copies can sit on one bus. The block drives SDA only as an open-drain pull-down enable.

A write transfer loads a register pointer from its first byte. Each later byte is stored at the pointer, and the pointer then steps forward. A read transfer returns bytes from the current pointer until the host declines a byte. The pointer keeps its value between transfers. A bank of read-only identity registers sits high in the address space. While the `busy_i` input is high, for example during a configuration load after power-up, the block refuses its address, so the host cannot reach the registers.

Top module: `smb_regport`

## Requirements
- R1: After reset, `sda_oe_o` is low, the register pointer is 0x00, and every writable register reads 0x00.
- R2: SDA falling while SCL is high (START) begins a new address phase from any state, including part way through a byte. SDA rising while SCL is high (STOP) returns the block to idle with SDA released. A byte cut short by STOP is discarded.
- R3: After START the block takes in eight bits, MSB first: seven address bits, then a direction bit (0 write, 1 read). It accepts the address when the upper five bits are 10101 and the lower two equal `strap_i`. It signals acceptance by pulling SDA low from the SCL low phase before the ninth clock through the high phase of that clock.
- R4: When `busy_i` is high as the address acknowledge is decided, the block does not acknowledge and ignores the rest of the transfer.
- R5: The block changes `sda_oe_o` only while SCL is low.
- R6: In a write transfer, the first byte after the address loads the register pointer. Each later byte is stored at the pointer. The block acknowledges every byte.
- R7: In a read transfer the block drives the register at the pointer, MSB first. After a host acknowledge (SDA low on the ninth clock) it sends the next byte. After a host non-acknowledge it releases SDA and drives nothing until the next START.
- R8: Read-only identity registers return 0x41 at 0x93, 0x3E at 0x94, `REV_ID` (default 0x02) at 0x95, `MARK_A` (default 0x5A) at 0x96 and `MARK_B` (default 0xC3) at 0x97. Writes to them are acknowledged and then dropped.
- R9: The pointer steps by one after every data byte written or read, wrapping from 0xFF to 0x00. It keeps its value between transfers, so a read with no pointer byte carries on from where the last transfer stopped.
- R10: On an address mismatch the block sends no acknowledge and keeps SDA released until the next START. Its register contents and pointer are left unchanged.
- R11: Writable registers occupy 0x00 to `NUM_RW`-1 (default 0x0F). Any other address outside the identity bank reads 0x00, and writes to it are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled level of the bus clock line |
| sda_i | input | 1 | Sampled level of the bus data line |
| strap_i | input | 2 | Address strap, the two lowest address bits |
| busy_i | input | 1 | High while the block must refuse bus access |
| sda_oe_o | output | 1 | High to pull SDA low (open drain) |

## Verification
The assertions assume the host behaves as a legal bus master. SDA moves while SCL is high only to form START or STOP. Each SCL phase lasts longer than the synchroniser latency of three system clocks. `busy_i` is synchronous to `clk`. The bench meets these conditions by holding every SCL half period for eight system clocks. After each SCL falling edge it waits two more clocks before it moves SDA, so the sampled lines never show SCL and SDA changing in the same cycle. Random traffic uses the same bit-level tasks, so it stays within these rules too.

// File: rtl/smb_pkg.sv
// Shared constants and types of the bus register slave.
// Assumes an 8-bit register pointer and byte-wide registers.
package smb_pkg;
    localparam int BYTE_W = 8;
    localparam int PTR_W  = 8;
    localparam int CNT_W  = 4;

    localparam logic [4:0]        ADDR_PREFIX = 5'b10101;
    localparam logic [PTR_W-1:0]  ID_BASE     = 8'h93;
    localparam logic [BYTE_W-1:0] ID_MAKER    = 8'h41;
    localparam logic [BYTE_W-1:0] ID_PART     = 8'h3E;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WBYTE,
        ST_WACK,
        ST_RBYTE,
        ST_RACK
    } smb_state_e;
endpackage

// File: rtl/smb_sync_edge.sv
// Line conditioner: brings SCL and SDA into the clock domain through a
// SYNC_STAGES-deep flop chain and flags SCL edges, START and STOP.
// Assumes each bus phase is longer than SYNC_STAGES+1 clocks.
module smb_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_ff;
    logic [SYNC_STAGES-1:0] sda_ff;
    logic                   scl_d;
    logic                   sda_d;

    // Synchroniser chains, idle-high after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
        end else begin
            scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
        end
    end

    // One-cycle history of the synchronised lines for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // Edge and bus-condition decode.
    always_comb begin
        scl_s     = scl_ff[SYNC_STAGES-1];
        sda_s     = sda_ff[SYNC_STAGES-1];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/smb_bus_fsm.sv
// Byte engine: follows the bus bit by bit on SCL edges, matches the
// address, drives acknowledge and read data, and owns the register pointer.
// Assumes the conditioned strobes of smb_sync_edge. All SDA changes are
// made on a detected SCL fall, so they happen while SCL is low.
module smb_bus_fsm
    import smb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [1:0]        strap,
    input  logic              busy,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  ptr,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              addr_ack,
    output logic              idle
);
    smb_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic              rw;
    logic              first;
    logic              macked;
    logic              addr_hit;

    // Address compare against fixed prefix plus straps.
    always_comb begin
        addr_hit = (shreg[7:1] == {ADDR_PREFIX, strap});
        idle     = (state == ST_IDLE);
    end

    // Main transfer sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            rw       <= 1'b0;
            first    <= 1'b0;
            macked   <= 1'b0;
            sda_oe   <= 1'b0;
            ptr      <= '0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            addr_ack <= 1'b0;
        end else begin
            wr_en    <= 1'b0;
            addr_ack <= 1'b0;
            if (start_det) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg <= {shreg[6:0], sda_s};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            if (addr_hit && !busy) begin
                                sda_oe   <= 1'b1;
                                rw       <= shreg[0];
                                addr_ack <= 1'b1;
                                state    <= ST_AACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                state  <= ST_RBYTE;
                            end else begin
                                sda_oe <= 1'b0;
                                first  <= 1'b1;
                                state  <= ST_WBYTE;
                            end
                        end
                    end
                    ST_WBYTE: begin
                        if (scl_rise) begin
                            shreg <= {shreg[6:0], sda_s};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            sda_oe <= 1'b1;
                            first  <= 1'b0;
                            state  <= ST_WACK;
                            if (first) begin
                                ptr <= shreg;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= shreg;
                                ptr     <= ptr + 1'b1;
                            end
                        end
                    end
                    ST_WACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            state  <= ST_WBYTE;
                        end
                    end
                    ST_RBYTE: begin
                        if (scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (cnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                ptr    <= ptr + 1'b1;
                                state  <= ST_RACK;
                            end else begin
                                shreg  <= {shreg[6:0], 1'b0};
                                sda_oe <= ~shreg[6];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            macked <= ~sda_s;
                        end else if (scl_fall) begin
                            if (macked) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                cnt    <= '0;
                                state  <= ST_RBYTE;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/smb_regfile.sv
// Register store: NUM_RW writable byte registers from address 0 upward,
// a read-only identity bank at ID_BASE..ID_BASE+4, zero elsewhere.
// Assumes NUM_RW is a power of two no larger than 128.
module smb_regfile
    import smb_pkg::*;
#(
    parameter int                NUM_RW = 16,
    parameter logic [BYTE_W-1:0] REV_ID = 8'h02,
    parameter logic [BYTE_W-1:0] MARK_A = 8'h5A,
    parameter logic [BYTE_W-1:0] MARK_B = 8'hC3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int IDX_W = $clog2(NUM_RW);

    logic [NUM_RW-1:0][BYTE_W-1:0] regs;
    logic [NUM_RW-1:0]             wsel;

    // Per-register write select.
    for (genvar gi = 0; gi < NUM_RW; gi++) begin : g_wsel
        assign wsel[gi] = wr_en && (wr_addr == PTR_W'(gi));
    end

    // Writable register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs <= '0;
        end else begin
            for (int i = 0; i < NUM_RW; i++) begin
                if (wsel[i]) regs[i] <= wr_data;
            end
        end
    end

    // Read decode over writable, identity and empty space.
    always_comb begin
        rd_data = '0;
        if (rd_addr < PTR_W'(NUM_RW)) begin
            rd_data = regs[rd_addr[IDX_W-1:0]];
        end else begin
            case (rd_addr)
                ID_BASE:         rd_data = ID_MAKER;
                ID_BASE + 8'd1:  rd_data = ID_PART;
                ID_BASE + 8'd2:  rd_data = REV_ID;
                ID_BASE + 8'd3:  rd_data = MARK_A;
                ID_BASE + 8'd4:  rd_data = MARK_B;
                default:         rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/smb_regport.sv
// Top of the bus register slave: line conditioner, byte engine and
// register store. SDA is open drain; sda_oe_o high pulls it low.
// Assumes busy_i is synchronous to clk.
module smb_regport
    import smb_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter int                NUM_RW      = 16,
    parameter logic [BYTE_W-1:0] REV_ID      = 8'h02,
    parameter logic [BYTE_W-1:0] MARK_A      = 8'h5A,
    parameter logic [BYTE_W-1:0] MARK_B      = 8'hC3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] strap_i,
    input  logic       busy_i,
    output logic       sda_oe_o
);
    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic [PTR_W-1:0]  reg_ptr;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_addr;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] rd_data;
    logic              addr_ack;
    logic              fsm_idle;

    smb_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_bus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .strap     (strap_i),
        .busy      (busy_i),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe_o),
        .ptr       (reg_ptr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .addr_ack  (addr_ack),
        .idle      (fsm_idle)
    );

    smb_regfile #(
        .NUM_RW (NUM_RW),
        .REV_ID (REV_ID),
        .MARK_A (MARK_A),
        .MARK_B (MARK_B)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (reg_ptr),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/smb_regport_chk.sv
// Property checker for smb_regport, attached by bind below.
// Assumes a legal host: SDA moves with SCL high only for START/STOP.
module smb_regport_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       stop_det,
    input logic       addr_ack,
    input logic       fsm_idle,
    input logic       busy_i,
    input logic       sda_oe_o,
    input logic [7:0] reg_ptr,
    input logic [7:0] rd_data
);
    // STOP leaves SDA released.
    assert_stop_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe_o);

    // Address acknowledge starts during an SCL low phase.
    assert_ack_low_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ack |-> !scl_s);

    // No acknowledge while busy was high at the decision.
    assert_busy_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ack |-> $past(!busy_i));

    // Output enable only moves while SCL is low.
    assert_oe_moves_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !$past(scl_s));

    // Identity bytes are fixed.
    assert_id_maker_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_ptr == 8'h93) |-> (rd_data == 8'h41));
    assert_id_part_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_ptr == 8'h94) |-> (rd_data == 8'h3E));

    // Idle block never pulls the line.
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_idle |-> !sda_oe_o);
endmodule

bind smb_regport smb_regport_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .stop_det (stop_det),
    .addr_ack (addr_ack),
    .fsm_idle (fsm_idle),
    .busy_i   (busy_i),
    .sda_oe_o (sda_oe_o),
    .reg_ptr  (reg_ptr),
    .rd_data  (rd_data)
);

// File: tb/smb_regport_bench.sv
`timescale 1ns/1ps
module smb_regport_bench;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b01;
    logic       busy = 1'b0;
    logic       sda_oe;
    logic       sda_line;

    int total = 0;
    int bad = 0;
    int oe_cnt = 0;
    int r5_viol = 0;
    logic oe_prev = 1'b0;

    logic [7:0] model [16];
    logic [7:0] mptr;
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];

    always #2 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    smb_regport u_smb_regport (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .strap_i  (strap),
        .busy_i   (busy),
        .sda_oe_o (sda_oe)
    );

    // Line monitor, sampled just after each edge.
    always @(posedge clk) begin
        #1;
        if (sda_oe) oe_cnt++;
        if (rst_n && (sda_oe != oe_prev) && scl) r5_viol++;
        oe_prev = sda_oe;
    end

    function automatic logic [7:0] exp_val(input logic [7:0] a);
        if (a < 8'd16) return model[a[3:0]];
        case (a)
            8'h93: return 8'h41;
            8'h94: return 8'h3E;
            8'h95: return 8'h02;
            8'h96: return 8'h5A;
            8'h97: return 8'hC3;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_c(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wait_c(H);
        scl = 1'b1;   wait_c(H);
        sda_m = 1'b0; wait_c(H);
        scl = 1'b0;   wait_c(H);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wait_c(H);
        scl = 1'b1;   wait_c(H);
        sda_m = 1'b1; wait_c(H);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wait_c(H);
        scl = 1'b1; wait_c(H);
        scl = 1'b0; wait_c(2);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wait_c(H);
        scl = 1'b1; wait_c(H/2);
        b = sda_line; wait_c(H/2);
        scl = 1'b0; wait_c(2);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic ack_m);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(~ack_m);
    endtask

    task automatic do_write(input logic [6:0] a7, input logic [7:0] p,
                            input int n, output logic ok);
        logic ack;
        bus_start;
        send_byte({a7, 1'b0}, ack);
        ok = ack;
        if (ack) begin
            send_byte(p, ack); ok &= ack;
            for (int i = 0; i < n; i++) begin
                send_byte(wbuf[i], ack); ok &= ack;
            end
        end
        bus_stop;
    endtask

    task automatic model_write(input logic [7:0] p, input int n);
        mptr = p;
        for (int i = 0; i < n; i++) begin
            if (mptr < 8'd16) model[mptr[3:0]] = wbuf[i];
            mptr++;
        end
    endtask

    task automatic do_read(input logic [6:0] a7, input logic set_ptr,
                           input logic [7:0] p, input int n, output logic ok);
        logic ack;
        ok = 1'b1;
        if (set_ptr) begin
            bus_start;
            send_byte({a7, 1'b0}, ack); ok &= ack;
            send_byte(p, ack); ok &= ack;
        end
        bus_start;
        send_byte({a7, 1'b1}, ack); ok &= ack;
        for (int i = 0; i < n; i++) recv_byte(rbuf[i], i != n - 1);
        bus_stop;
    endtask

    task automatic check_read(input string req, input logic set_ptr,
                              input logic [7:0] p, input int n);
        if (set_ptr) mptr = p;
        for (int i = 0; i < n; i++) begin
            chk(req, "read byte", rbuf[i], exp_val(mptr));
            mptr++;
        end
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic       ok;
        logic       ack;
        logic       b;
        logic [6:0] own;
        logic [7:0] x;
        int unsigned seed;
        seed = 32'h5EED_1234;
        x = 8'($urandom(seed));
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        mptr = 8'h00;
        own = {5'b10101, strap};

        wait_c(6);
        rst_n = 1'b1;
        wait_c(4);
        chk("R1", "oe after reset", sda_oe, 1'b0);

        // R1: pointer starts at 0 and registers are clear.
        do_read(own, 1'b0, 8'h00, 2, ok);
        chk("R1", "ack", ok, 1'b1);
        check_read("R1", 1'b0, 8'h00, 2);

        // R8: identity bank.
        do_read(own, 1'b1, 8'h93, 5, ok);
        chk("R8", "ack", ok, 1'b1);
        check_read("R8", 1'b1, 8'h93, 5);
        wbuf[0] = 8'h00; wbuf[1] = 8'hFF;
        do_write(own, 8'h93, 2, ok);
        chk("R8", "write to id acked", ok, 1'b1);
        model_write(8'h93, 2);
        do_read(own, 1'b1, 8'h93, 2, ok);
        check_read("R8", 1'b1, 8'h93, 2);

        // R6 and R11: burst across the end of the writable range.
        wbuf[0] = 8'hAA; wbuf[1] = 8'hBB; wbuf[2] = 8'hCC;
        do_write(own, 8'h0E, 3, ok);
        chk("R6", "burst acked", ok, 1'b1);
        model_write(8'h0E, 3);
        do_read(own, 1'b1, 8'h0E, 3, ok);
        check_read("R11", 1'b1, 8'h0E, 3);

        // R9: pointer carries across transfers and wraps.
        wbuf[0] = 8'h12; wbuf[1] = 8'h34; wbuf[2] = 8'h56; wbuf[3] = 8'h78;
        do_write(own, 8'h02, 2, ok);
        model_write(8'h02, 2);
        do_read(own, 1'b0, 8'h00, 2, ok);
        check_read("R9", 1'b0, 8'h00, 2);
        do_read(own, 1'b1, 8'hFF, 2, ok);
        check_read("R9", 1'b1, 8'hFF, 2);

        // R10: mismatching straps and prefix are ignored.
        oe_cnt = 0;
        bus_start;
        send_byte({5'b10101, ~strap, 1'b0}, ack);
        chk("R10", "no ack on strap mismatch", ack, 1'b0);
        send_byte(8'h05, ack);
        chk("R10", "no ack on data", ack, 1'b0);
        bus_stop;
        bus_start;
        send_byte({5'b00101, strap, 1'b0}, ack);
        chk("R10", "no ack on prefix mismatch", ack, 1'b0);
        bus_stop;
        chk("R10", "line untouched", oe_cnt, 0);
        do_read(own, 1'b0, 8'h00, 1, ok);
        check_read("R10", 1'b0, 8'h00, 1);

        // R4: busy refuses access.
        busy = 1'b1;
        wbuf[0] = 8'h77;
        do_write(own, 8'h01, 1, ok);
        chk("R4", "no ack while busy", ok, 1'b0);
        busy = 1'b0;
        do_read(own, 1'b1, 8'h01, 1, ok);
        chk("R4", "ack after busy", ok, 1'b1);
        check_read("R4", 1'b1, 8'h01, 1);

        // R3: strap change moves the address.
        strap = 2'b10;
        wbuf[0] = 8'h9D;
        do_write(own, 8'h07, 1, ok);
        chk("R3", "old address refused", ok, 1'b0);
        own = {5'b10101, strap};
        do_write(own, 8'h07, 1, ok);
        chk("R3", "new address acked", ok, 1'b1);
        model_write(8'h07, 1);
        do_read(own, 1'b1, 8'h07, 1, ok);
        check_read("R3", 1'b1, 8'h07, 1);

        // R7: non-acknowledge releases the line.
        bus_start;
        send_byte({own, 1'b0}, ack);
        send_byte(8'h93, ack);
        bus_start;
        send_byte({own, 1'b1}, ack);
        recv_byte(rbuf[0], 1'b1);
        recv_byte(rbuf[1], 1'b0);
        oe_cnt = 0;
        for (int i = 0; i < 9; i++) get_bit(b);
        chk("R7", "released after nack", oe_cnt, 0);
        bus_stop;
        check_read("R7", 1'b1, 8'h93, 2);

        // R2: STOP inside a data byte discards it.
        wbuf[0] = 8'h66;
        do_write(own, 8'h06, 1, ok);
        model_write(8'h06, 1);
        bus_start;
        send_byte({own, 1'b0}, ack);
        send_byte(8'h06, ack);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        bus_stop;
        chk("R2", "oe after stop", sda_oe, 1'b0);
        do_read(own, 1'b0, 8'h00, 1, ok);
        check_read("R2", 1'b1, 8'h06, 1);

        // R2: START inside the address byte restarts cleanly.
        bus_start;
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_start;
        send_byte({own, 1'b0}, ack);
        chk("R2", "ack after restart", ack, 1'b1);
        send_byte(8'h03, ack);
        send_byte(8'h3C, ack);
        bus_stop;
        wbuf[0] = 8'h3C;
        model_write(8'h03, 1);
        do_read(own, 1'b1, 8'h03, 1, ok);
        check_read("R2", 1'b1, 8'h03, 1);

        // R6, R9, R11: random bursts checked against the model.
        for (int it = 0; it < 25; it++) begin
            logic [7:0] p;
            int n;
            p = 8'($urandom % 20);
            n = 1 + int'($urandom % 4);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            do_write(own, p, n, ok);
            chk("R6", "random write acked", ok, 1'b1);
            model_write(p, n);
            if ($urandom % 3 == 0) begin
                do_read(own, 1'b0, 8'h00, 2, ok);
                check_read("R9", 1'b0, 8'h00, 2);
            end else begin
                do_read(own, 1'b1, p, n, ok);
                check_read("R6", 1'b1, p, n);
            end
        end

        chk("R5", "oe changes with scl high", r5_viol, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule